// File: doc/BRIEF.md
# Register-Resident Transmit Descriptor Ring

This block is a transmit engine whose four descriptors are flip-flops inside the block, not structures in memory. Each slot has three words: an address word, a length word and a status word. The address word carries the buffer address, an enable bit and a done bit. Software fills the length word, then writes the buffer address with the enable bit set. The engine works through the slots in ring order. For each byte of the frame it issues a single-byte memory read. It forwards the returned bytes on a byte stream. When the frame ends it marks the slot done and raises a one-cycle interrupt pulse.

The engine owns the ring position, which shows on a port and in two bits of slot 0's address word, so software can find where the hardware will start. A frame shorter than the minimum is padded with zero bytes up to the minimum, and its length word then reads back the minimum. The transmit result comes in on four cause lines and is stored in the status word. The stored value is a summary abort flag plus those causes.

Both the memory request and the byte stream use valid/ready. A source holds valid, and every field travelling with it, unchanged until it sees ready. The engine keeps at most one memory read outstanding. It accepts the single-cycle response in the cycle after the request is taken or in any later cycle. The register port is plain: a write strobe, an address and write data, and a read that returns data in the same cycle for whatever address is presented.

Top module: `txr_ring`

## Requirements
- R1: After reset, every word of every slot reads zero, the ring position is 0, and mem_req_valid, tx_valid and done_irq are low.
- R2: reg_addr is {slot[1:0], word[1:0]}. Word 0 (address word) holds the buffer address in [31:4], done in bit 1 and enable in bit 0. Bits [3:2] read the ring position for slot 0 and zero for the other slots. Word 1 holds the length in [9:0], and upper bits written there are dropped. Word 2 is the status word. Word 3 reads zero.
- R3: Each enabled slot is sent in ring order. Byte n of a frame is fetched from address base+n, and the bytes appear on tx_data in order. tx_last is high only on the final byte.
- R4: The engine does not start while the slot at the ring position has enable clear, even if other slots are enabled.
- R5: On the final byte's handshake, the slot's done bit is set and its enable bit is cleared. done_irq pulses for exactly one cycle, and the ring position advances by one, wrapping from 3 to 0.
- R6: An address-word write with bit 1 = 0 clears done. An address-word write with bit 0 = 1 clears both done and status. A length write of 0 reads back 0.
- R7: A frame whose length is under 60 is followed by zero bytes up to 60 bytes in total. No memory read is made for the padding, and the length word then reads 60. A length of 60 or more is sent as written and is left unchanged.
- R8: line_err is sampled on the final byte's handshake. Its bits are [0] jabber timeout, [1] underrun, [2] no carrier and [3] loss of carrier. The status word becomes {line_err, abort} in bits [4:0], where abort is set if any cause bit is set.
- R9: mem_req_valid with mem_req_addr, and tx_valid with tx_data and tx_last, stay unchanged until the matching ready is seen.
- R10: Writes to the status word are ignored. Writes to the address or length word of the slot the engine is sending are also ignored; this includes the cycle the engine starts on that slot and the cycle it completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Slot and word select for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| mem_req_valid | output | 1 | Single-byte memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the request |
| mem_rsp_valid | input | 1 | Read data is present for one cycle |
| mem_rsp_data | input | 8 | Read data byte |
| tx_valid | output | 1 | Frame byte is present |
| tx_ready | input | 1 | Downstream takes the byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| line_err | input | 4 | Transmit result causes, sampled on the final byte |
| done_irq | output | 1 | One-cycle pulse per completed slot |
| ring_pos | output | 2 | Slot the engine serves next or is serving now |

## Verification
Completion of the active slot and a software write to the next slot can land on the same clock edge. The first updates the ring position and the done bit. The second changes the length the engine is about to latch. The bench provokes this by waiting for the cycle in which the final byte's handshake is certain and issuing a length write to the following, already enabled slot in that cycle. It judges the result by the following frame: that frame must carry the newly written length, and the completed slot must still read done with its own original length.

// File: rtl/txr_pkg.sv
package txr_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_FETCH = 2'd1,
    ENG_WAIT  = 2'd2,
    ENG_SEND  = 2'd3
  } eng_state_e;

  localparam logic [1:0] WSEL_ADDR = 2'd0;
  localparam logic [1:0] WSEL_LEN  = 2'd1;
  localparam logic [1:0] WSEL_STAT = 2'd2;

  localparam int CAUSE_W = 4;
  localparam int STAT_W  = CAUSE_W + 1;

endpackage

// File: rtl/txr_desc_regs.sv
module txr_desc_regs
  import txr_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int AW     = 32,
  parameter int LEN_W  = 10,
  parameter int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [1:0]        wr_word,
  input  logic [AW-1:0]     wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [1:0]        rd_word,
  output logic [AW-1:0]     rd_data,
  input  logic [SLOT_W-1:0] head,
  input  logic              lock,
  input  logic              cmpl,
  input  logic [LEN_W-1:0]  cmpl_len,
  input  logic [STAT_W-1:0] cmpl_stat,
  output logic              head_en,
  output logic [AW-5:0]     head_base,
  output logic [LEN_W-1:0]  head_len
);

  localparam int BASE_W = AW - 4;

  logic [NSLOT-1:0]             en_all;
  logic [NSLOT-1:0]             done_all;
  logic [NSLOT-1:0][BASE_W-1:0] base_all;
  logic [NSLOT-1:0][LEN_W-1:0]  len_all;
  logic [NSLOT-1:0][STAT_W-1:0] stat_all;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic              en_q;
    logic              done_q;
    logic [BASE_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q;
    logic [STAT_W-1:0] stat_q;
    logic              own;
    logic              hit;

    assign own = (head == SLOT_W'(i));
    assign hit = wr_en && (wr_slot == SLOT_W'(i)) && !(lock && own);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q   <= 1'b0;
        done_q <= 1'b0;
        base_q <= '0;
        len_q  <= '0;
        stat_q <= '0;
      end else if (cmpl && own) begin
        en_q   <= 1'b0;
        done_q <= 1'b1;
        len_q  <= cmpl_len;
        stat_q <= cmpl_stat;
      end else if (hit) begin
        case (wr_word)
          WSEL_ADDR: begin
            base_q <= wr_data[AW-1:4];
            en_q   <= wr_data[0];
            done_q <= done_q & wr_data[1] & ~wr_data[0];
            if (wr_data[0]) stat_q <= '0;
          end
          WSEL_LEN: len_q <= wr_data[LEN_W-1:0];
          default: ;
        endcase
      end
    end

    assign en_all[i]   = en_q;
    assign done_all[i] = done_q;
    assign base_all[i] = base_q;
    assign len_all[i]  = len_q;
    assign stat_all[i] = stat_q;
  end

  logic [1:0] pos_field;
  assign pos_field = (rd_slot == '0) ? 2'(head) : 2'b00;

  always_comb begin
    rd_data = '0;
    case (rd_word)
      WSEL_ADDR: rd_data = {base_all[rd_slot], pos_field, done_all[rd_slot], en_all[rd_slot]};
      WSEL_LEN:  rd_data = AW'(len_all[rd_slot]);
      WSEL_STAT: rd_data = AW'(stat_all[rd_slot]);
      default:   rd_data = '0;
    endcase
  end

  assign head_en   = en_all[head];
  assign head_base = base_all[head];
  assign head_len  = len_all[head];

  AST_LOCKED_SLOT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !cmpl) |=> (head_base == $past(head_base) && head_len == $past(head_len))); // R10

  AST_ACTIVE_STAYS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !cmpl) |=> head_en); // R5

endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
#(
  parameter int AW      = 32,
  parameter int LEN_W   = 10,
  parameter int MIN_LEN = 60,
  parameter int SLOT_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               head_en,
  input  logic [AW-5:0]      head_base,
  input  logic [LEN_W-1:0]   head_len,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [AW-1:0]      mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [7:0]         mem_rsp_data,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [7:0]         tx_data,
  output logic               tx_last,
  input  logic [CAUSE_W-1:0] line_err,
  output logic [SLOT_W-1:0]  head,
  output logic               lock,
  output logic               cmpl,
  output logic [LEN_W-1:0]   cmpl_len,
  output logic [STAT_W-1:0]  cmpl_stat,
  output logic               done_irq
);

  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

  eng_state_e        st_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  tot_q;
  logic [AW-5:0]     base_q;
  logic [7:0]        byte_q;
  logic [SLOT_W-1:0] head_q;
  logic              irq_q;

  logic             start;
  logic             last;
  logic [LEN_W-1:0] next_cnt;

  assign start    = (st_q == ENG_IDLE) && head_en;
  assign last     = (cnt_q == tot_q - 1'b1);
  assign next_cnt = cnt_q + 1'b1;
  assign cmpl     = (st_q == ENG_SEND) && tx_ready && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      cnt_q  <= '0;
      len_q  <= '0;
      tot_q  <= '0;
      base_q <= '0;
      byte_q <= '0;
      head_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= cmpl;
      case (st_q)
        ENG_IDLE: begin
          if (head_en) begin
            base_q <= head_base;
            len_q  <= head_len;
            tot_q  <= (head_len < MIN_L) ? MIN_L : head_len;
            cnt_q  <= '0;
            byte_q <= '0;
            st_q   <= (head_len != '0) ? ENG_FETCH : ENG_SEND;
          end
        end
        ENG_FETCH: begin
          if (mem_req_ready) st_q <= ENG_WAIT;
        end
        ENG_WAIT: begin
          if (mem_rsp_valid) begin
            byte_q <= mem_rsp_data;
            st_q   <= ENG_SEND;
          end
        end
        ENG_SEND: begin
          if (tx_ready) begin
            if (last) begin
              st_q   <= ENG_IDLE;
              head_q <= head_q + 1'b1;
            end else begin
              cnt_q <= next_cnt;
              if (next_cnt < len_q) begin
                st_q <= ENG_FETCH;
              end else begin
                byte_q <= '0;
                st_q   <= ENG_SEND;
              end
            end
          end
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st_q == ENG_FETCH);
  assign mem_req_addr  = {base_q, 4'b0000} + AW'(cnt_q);
  assign tx_valid      = (st_q == ENG_SEND);
  assign tx_data       = byte_q;
  assign tx_last       = (st_q == ENG_SEND) && last;
  assign lock          = (st_q != ENG_IDLE) || start;
  assign cmpl_len      = tot_q;
  assign cmpl_stat     = {line_err, |line_err};
  assign head          = head_q;
  assign done_irq      = irq_q;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R9

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9

  AST_IRQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (head == $past(head) + 1'b1)); // R5

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq); // R5

  AST_PAD_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (cnt_q < len_q)); // R7

endmodule

// File: rtl/txr_ring.sv
module txr_ring
  import txr_pkg::*;
#(
  parameter int NSLOT   = 4,
  parameter int AW      = 32,
  parameter int LEN_W   = 10,
  parameter int MIN_LEN = 60,
  parameter int SLOT_W  = $clog2(NSLOT),
  parameter int RA_W    = SLOT_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [RA_W-1:0]    reg_addr,
  input  logic [AW-1:0]      reg_wdata,
  output logic [AW-1:0]      reg_rdata,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [AW-1:0]      mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [7:0]         mem_rsp_data,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [7:0]         tx_data,
  output logic               tx_last,
  input  logic [CAUSE_W-1:0] line_err,
  output logic               done_irq,
  output logic [SLOT_W-1:0]  ring_pos
);

  logic [SLOT_W-1:0] head;
  logic              lock;
  logic              cmpl;
  logic [LEN_W-1:0]  cmpl_len;
  logic [STAT_W-1:0] cmpl_stat;
  logic              head_en;
  logic [AW-5:0]     head_base;
  logic [LEN_W-1:0]  head_len;

  txr_desc_regs #(
    .NSLOT (NSLOT),
    .AW    (AW),
    .LEN_W (LEN_W),
    .SLOT_W(SLOT_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .wr_slot  (reg_addr[RA_W-1:2]),
    .wr_word  (reg_addr[1:0]),
    .wr_data  (reg_wdata),
    .rd_slot  (reg_addr[RA_W-1:2]),
    .rd_word  (reg_addr[1:0]),
    .rd_data  (reg_rdata),
    .head     (head),
    .lock     (lock),
    .cmpl     (cmpl),
    .cmpl_len (cmpl_len),
    .cmpl_stat(cmpl_stat),
    .head_en  (head_en),
    .head_base(head_base),
    .head_len (head_len)
  );

  txr_engine #(
    .AW     (AW),
    .LEN_W  (LEN_W),
    .MIN_LEN(MIN_LEN),
    .SLOT_W (SLOT_W)
  ) u_eng (
    .clk          (clk),
    .rst_n        (rst_n),
    .head_en      (head_en),
    .head_base    (head_base),
    .head_len     (head_len),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_data      (tx_data),
    .tx_last      (tx_last),
    .line_err     (line_err),
    .head         (head),
    .lock         (lock),
    .cmpl         (cmpl),
    .cmpl_len     (cmpl_len),
    .cmpl_stat    (cmpl_stat),
    .done_irq     (done_irq)
  );

  assign ring_pos = head;

endmodule

// File: tb/test_txr_ring.sv
module test_txr_ring;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [7:0]  mem_rsp_data;
  logic        tx_valid;
  logic        tx_ready;
  logic [7:0]  tx_data;
  logic        tx_last;
  logic [3:0]  line_err = '0;
  logic        done_irq;
  logic [1:0]  ring_pos;

  always #(CLK_PERIOD/2) clk = ~clk;

  txr_ring i_txr_ring (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .line_err(line_err),
    .done_irq(done_irq), .ring_pos(ring_pos)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  bit bp = 1'b0;

  logic [7:0] cap [0:4095];
  int cap_cnt = 0;
  int last_cnt = 0;
  int last_idx = -1;
  int req_cnt = 0;
  int irq_cnt = 0;

  // memory responder: byte at address a is a[7:0] ^ 8'h5A
  initial begin
    int k;
    int rsp_wait;
    logic [7:0] pend;
    k = 0; rsp_wait = -1; pend = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      k++;
      mem_rsp_valid = 1'b0;
      if (rsp_wait == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pend;
        rsp_wait = -1;
      end else if (rsp_wait > 0) begin
        rsp_wait--;
      end
      mem_req_ready = !bp || (k % 3 != 0);
      if (mem_req_valid && mem_req_ready) begin
        pend = mem_req_addr[7:0] ^ 8'h5A;
        req_cnt++;
        rsp_wait = bp ? 2 : 0;
      end
    end
  end

  // byte sink and interrupt counter
  initial begin
    int k;
    k = 0;
    tx_ready = 1'b1;
    forever begin
      @(negedge clk);
      k++;
      tx_ready = !bp || (k % 5 < 2);
      if (tx_valid && tx_ready) begin
        cap[cap_cnt] = tx_data;
        if (tx_last) begin
          last_cnt++;
          last_idx = cap_cnt;
        end
        cap_cnt++;
      end
      if (done_irq) irq_cnt++;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not end, got running expected finished");
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic reg_write(input int slot, input int word, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(slot * 4 + word); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input int slot, input int word, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 4'(slot * 4 + word);
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_done(input int slot, input string req);
    logic [31:0] v;
    v = '0;
    for (int k = 0; k < 20000; k++) begin
      reg_read(slot, 0, v);
      if (v[1]) break;
    end
    chk(v[1] == 1'b1, req, "completion seen", longint'(v[1]), 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_frame(input int first, input logic [31:0] base, input int len,
                           input string req, input string what);
    int tot;
    int bad;
    logic [31:0] a;
    logic [7:0] e;
    logic [7:0] g_got;
    logic [7:0] g_exp;
    tot = (len < 60) ? 60 : len;
    bad = 0; g_got = '0; g_exp = '0;
    for (int n = 0; n < tot; n++) begin
      a = base + 32'(n);
      e = (n < len) ? (a[7:0] ^ 8'h5A) : 8'h00;
      if (cap[first + n] !== e) begin
        if (bad == 0) begin g_got = cap[first + n]; g_exp = e; end
        bad++;
      end
    end
    chk(bad == 0, req, what, longint'(g_got), longint'(g_exp));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    int nz;
    nz = 0;
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++) begin
        reg_read(s, w, v);
        if (v != 0) nz++;
      end
    chk(nz == 0, "R1", "nonzero words after reset", nz, 0);
    chk(ring_pos == 2'd0, "R1", "ring_pos", ring_pos, 0);
    chk(!tx_valid && !mem_req_valid && !done_irq, "R1", "outputs idle",
        {tx_valid, mem_req_valid, done_irq}, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    reg_write(2, 1, 32'h0000_FFFF);
    reg_read(2, 1, v);
    chk(v == 32'h3FF, "R2", "length field width", v, 32'h3FF);
    reg_write(1, 0, 32'h1234_5670);
    reg_read(1, 0, v);
    chk(v == 32'h1234_5670, "R2", "address word", v, 32'h1234_5670);
    reg_read(1, 3, v);
    chk(v == 0, "R2", "word 3", v, 0);
    reg_write(3, 2, 32'hFFFF_FFFF);
    reg_read(3, 2, v);
    chk(v == 0, "R10", "status write ignored", v, 0);
  endtask

  task automatic t_stall();
    logic [31:0] v;
    reg_write(1, 1, 32'd64);
    reg_write(1, 0, 32'h0000_1001);
    repeat (40) @(negedge clk);
    chk(cap_cnt == 0 && req_cnt == 0, "R4", "activity with slot 0 disabled",
        cap_cnt + req_cnt, 0);
    reg_read(1, 0, v);
    chk(v == 32'h0000_1001, "R4", "slot 1 still pending", v, 32'h1001);
    chk(ring_pos == 2'd0, "R4", "ring_pos", ring_pos, 0);
  endtask

  task automatic t_order();
    logic [31:0] v;
    reg_write(0, 1, 32'd70);
    reg_write(0, 0, 32'h0000_2001);
    wait_done(1, "R3");
    chk(cap_cnt == 134, "R3", "byte count two frames", cap_cnt, 134);
    chk(last_cnt == 2 && last_idx == 133, "R3", "last marker", last_idx, 133);
    chk_frame(0, 32'h2000, 70, "R3", "slot 0 bytes");
    chk_frame(70, 32'h1000, 64, "R3", "slot 1 bytes");
    chk(req_cnt == 134, "R3", "memory reads", req_cnt, 134);
    chk(irq_cnt == 2, "R5", "interrupt pulses", irq_cnt, 2);
    chk(ring_pos == 2'd2, "R5", "ring_pos", ring_pos, 2);
    reg_read(0, 0, v);
    chk(v == 32'h0000_200A, "R5", "slot 0 done with position", v, 32'h200A);
    reg_read(1, 0, v);
    chk(v == 32'h0000_1002, "R5", "slot 1 done", v, 32'h1002);
    reg_read(0, 1, v);
    chk(v == 32'd70, "R7", "long length unchanged", v, 70);
  endtask

  task automatic t_ack();
    logic [31:0] v;
    reg_write(0, 0, 32'h0000_2000);
    reg_read(0, 0, v);
    chk(v == 32'h0000_2008, "R6", "done cleared by ack", v, 32'h2008);
    reg_write(0, 1, 32'd0);
    reg_read(0, 1, v);
    chk(v == 0, "R6", "length zeroed", v, 0);
    reg_write(1, 0, 32'h0000_1000);
    reg_read(1, 0, v);
    chk(v == 32'h0000_1000, "R6", "slot 1 ack", v, 32'h1000);
  endtask

  task automatic t_pad();
    logic [31:0] v;
    int c0, r0;
    c0 = cap_cnt; r0 = req_cnt;
    line_err = 4'b0010;
    reg_write(2, 1, 32'd5);
    reg_write(2, 0, 32'h0000_3001);
    wait_done(2, "R7");
    line_err = 4'b0000;
    chk(cap_cnt - c0 == 60, "R7", "padded byte count", cap_cnt - c0, 60);
    chk_frame(c0, 32'h3000, 5, "R7", "padded bytes");
    chk(req_cnt - r0 == 5, "R7", "no reads for padding", req_cnt - r0, 5);
    reg_read(2, 1, v);
    chk(v == 32'd60, "R7", "length raised to minimum", v, 60);
    reg_read(2, 2, v);
    chk(v == 32'h05, "R8", "underrun status", v, 5);
    chk(ring_pos == 2'd3, "R5", "ring_pos", ring_pos, 3);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    int c0, r0;
    c0 = cap_cnt; r0 = req_cnt;
    line_err = 4'b1001;
    reg_write(3, 1, 32'd60);
    reg_write(3, 0, 32'h0000_4001);
    wait_done(3, "R5");
    line_err = 4'b0000;
    chk(cap_cnt - c0 == 60 && req_cnt - r0 == 60, "R7", "exact minimum fetched",
        req_cnt - r0, 60);
    chk_frame(c0, 32'h4000, 60, "R7", "minimum frame bytes");
    reg_read(3, 2, v);
    chk(v == 32'h13, "R8", "jabber and carrier loss status", v, 32'h13);
    chk(ring_pos == 2'd0, "R5", "ring_pos wrap", ring_pos, 0);
  endtask

  task automatic t_enable_clears();
    logic [31:0] v;
    int c0;
    c0 = cap_cnt;
    reg_write(2, 0, 32'h0000_5001);
    reg_read(2, 0, v);
    chk(v == 32'h0000_5001, "R6", "enable clears done", v, 32'h5001);
    reg_read(2, 2, v);
    chk(v == 0, "R6", "enable clears status", v, 0);
    repeat (20) @(negedge clk);
    chk(cap_cnt == c0, "R4", "stall on disabled slot 0", cap_cnt - c0, 0);
  endtask

  task automatic t_backpressure();
    logic [31:0] v;
    int c0, r0;
    c0 = cap_cnt; r0 = req_cnt;
    bp = 1'b1;
    reg_write(0, 1, 32'd61);
    reg_write(0, 0, 32'h0000_6001);
    wait_done(0, "R9");
    chk(cap_cnt - c0 == 61 && last_idx == cap_cnt - 1, "R9", "stalled frame count",
        cap_cnt - c0, 61);
    chk_frame(c0, 32'h6000, 61, "R9", "stalled frame bytes");
    chk(req_cnt - r0 == 61, "R9", "stalled reads", req_cnt - r0, 61);
    reg_read(0, 2, v);
    chk(v == 0, "R8", "clean status", v, 0);
    chk(ring_pos == 2'd1, "R5", "ring_pos", ring_pos, 1);
  endtask

  task automatic t_busy_same();
    logic [31:0] v;
    int c0, r0, i0, k;
    c0 = cap_cnt; r0 = req_cnt; i0 = irq_cnt;
    reg_write(1, 1, 32'd200);
    reg_write(1, 0, 32'h0000_7001);
    for (k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (req_cnt > r0) break;
    end
    reg_write(1, 1, 32'd3);
    reg_write(1, 0, 32'h0000_9991);
    for (k = 0; k < 20000; k++) begin
      @(negedge clk);
      #1;
      if (tx_valid && tx_ready && tx_last) break;
    end
    reg_wr = 1'b1; reg_addr = 4'(2 * 4 + 1); reg_wdata = 32'd62;
    @(negedge clk);
    reg_wr = 1'b0;
    wait_done(2, "R3");
    bp = 1'b0;
    chk(cap_cnt - c0 == 262, "R10", "bytes of busy and next frame", cap_cnt - c0, 262);
    chk_frame(c0, 32'h7000, 200, "R10", "busy frame kept original fields");
    chk_frame(c0 + 200, 32'h5000, 62, "R3", "next frame uses same-cycle length");
    reg_read(1, 0, v);
    chk(v == 32'h0000_7002, "R10", "busy address write ignored", v, 32'h7002);
    reg_read(1, 1, v);
    chk(v == 32'd200, "R10", "busy length write ignored", v, 200);
    reg_read(2, 1, v);
    chk(v == 32'd62, "R3", "next slot length", v, 62);
    chk(irq_cnt - i0 == 2, "R5", "interrupt pulses", irq_cnt - i0, 2);
    chk(ring_pos == 2'd3, "R5", "ring_pos", ring_pos, 3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regmap();
    t_stall();
    t_order();
    t_ack();
    t_pad();
    t_wrap();
    t_enable_clears();
    t_backpressure();
    t_busy_same();
    finish_run();
  end

endmodule